// File: doc/BRIEF.md
# Reset Sequencer with Clock Monitor

This block controls how a device comes out of reset and then watches its system clock. It runs on an internal reference clock that never stops. Once the power-on reset input goes high, it counts a fixed power-on delay and then an optional power-up timer delay, and after that it releases the system reset. For a crystal or PLL source it then adds a settling delay before the clock monitor may act. The CPU run enable stays low until the chosen source reports that it is usable, so a slow oscillator or an unlocked PLL never reaches the core.

When the monitor is enabled and active, it looks at a sampled activity signal taken from the monitored clock. If that signal shows no edge for a set number of reference cycles, the block switches the clock select to the internal fast RC oscillator. It also lets the CPU run on that clock and raises a trap request, which stays up until it is acknowledged. The fallback holds until the next power-on reset. All delays are parameters, so a simulation can use short values.

Top module: `rst_clk_sequencer`

## Requirements
- R1: While `rst_n` is low, and during the power-on count that follows, `sys_rst_rel`, `cpu_run` and `fail_trap` are 0 and `clk_sel` is 2'b00.
- R2: `sys_rst_rel` rises at the POR_CYCLES-th reference edge after `rst_n` goes high, plus PWRT_CYCLES more edges when `pwrt_en` is 1 at the end of the power-on count.
- R3: When `pwrt_en` is 0 at the end of the power-on count, the power-up timer delay is skipped completely.
- R4: Source encoding on `src_sel`: 2'b00 internal RC, 2'b01 crystal, 2'b10 and 2'b11 PLL. For crystal and PLL, monitoring begins SETTLE_CYCLES edges after reset release, and no failure can be flagged before that. For internal RC, monitoring begins at reset release.
- R5: `cpu_run` rises one edge after monitoring begins, at the earliest. It needs a valid clock: internal RC is always valid, crystal needs `osc_rdy`, PLL needs both `osc_rdy` and `pll_lock`. Until then `cpu_run` stays 0.
- R6: While `mon_en` is 1 and monitoring is active, a run of MISS_CYCLES reference cycles with no edge on the synchronised `clk_activity` makes the block enter fallback on the next edge. In fallback `clk_sel` is 2'b00, `cpu_run` is 1 and `fail_trap` is 1.
- R7: If a clock failure is detected in the same cycle that the clock becomes valid, the failure wins. The block goes straight to fallback and never passes through normal run.
- R8: `fail_trap` stays 1 until `trap_ack` is sampled high, and it clears on that edge. Fallback and `clk_sel` = 2'b00 hold until the next power-on reset.
- R9: With `mon_en` at 0, a missing clock never sets `fail_trap`. The block just waits for the valid-clock flags.
- R10: From reset release onward, `clk_sel` reports the source that `src_sel` held at release. Later changes on `src_sel` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running internal reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrt_en | input | 1 | Enables the power-up timer delay |
| mon_en | input | 1 | Enables clock-failure monitoring |
| src_sel | input | 2 | Configured clock source (00 RC, 01 crystal, 1x PLL) |
| osc_rdy | input | 1 | Oscillator start-up complete flag |
| pll_lock | input | 1 | PLL lock flag |
| clk_activity | input | 1 | Divided sample of the monitored clock, asynchronous |
| trap_ack | input | 1 | Clears the clock-fail trap request |
| sys_rst_rel | output | 1 | System reset released |
| cpu_run | output | 1 | CPU execution enable |
| clk_sel | output | 2 | Active clock source, 00 after a failure |
| fail_trap | output | 1 | Clock-fail trap request |

## Verification
Two things can happen in the same cycle: the monitor can declare a failure just as the valid-clock flags arrive while the block waits for a clock. The bench holds the activity sample still and keeps the PLL flags low until the edge right before the miss counter fills. It then raises both flags, so that clock-valid and failure land on the same edge. The result is judged on that edge. `fail_trap` must be 1, `clk_sel` must be the internal RC code and `cpu_run` must be 1, with no cycle where the PLL code appears without the trap.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_POR      = 3'd0,
    ST_PWRT     = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_WAIT_CLK = 3'd3,
    ST_RUN      = 3'd4,
    ST_FAILSAFE = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_FRC  = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_PLLX = 2'b11
  } clk_src_e;

  function automatic logic src_needs_settle(input clk_src_e s);
    return (s != SRC_FRC);
  endfunction

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == (limit - CNT_W'(1)));
  assign cnt_en = clr || !done;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count never runs past its terminal value
  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && done |=> (cnt_q == $past(cnt_q)) || $past(limit) != limit);

endmodule

// File: rtl/rstseq_clkmon.sv
module rstseq_clkmon #(
  parameter int MISS_CYCLES = 16,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic active,
  output logic fail
);

  localparam int MISS_W = $clog2(MISS_CYCLES + 1);
  localparam int PIPE_W = SYNC_DEPTH + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              act_edge;
  logic              at_lim;

  generate
    if (SYNC_DEPTH < 2) begin : g_bad_depth
      initial $error("SYNC_DEPTH must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[PIPE_W-2:0], activity};
  end

  assign act_edge = pipe_q[PIPE_W-1] ^ pipe_q[PIPE_W-2];
  assign at_lim   = (miss_q == MISS_W'(MISS_CYCLES - 1));
  assign fail     = active && !act_edge && at_lim;

  always_comb begin
    if (!active || act_edge) miss_d = '0;
    else if (at_lim)         miss_d = miss_q;
    else                     miss_d = miss_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= '0;
    else        miss_q <= miss_d;
  end

  // R6: the miss count saturates at its limit
  assert_miss_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MISS_W'(MISS_CYCLES - 1));

  // R9: an idle monitor holds no stale count
  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> miss_q == '0);

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrt_en,
  input  logic       mon_en,
  input  clk_src_e   src_sel,
  input  logic       osc_rdy,
  input  logic       pll_lock,
  input  logic       trap_ack,
  input  logic       mon_fail,
  input  logic       tmr_done,
  output seq_state_e state,
  output logic       tmr_clr,
  output logic       mon_active,
  output logic       sys_rst_rel,
  output logic       cpu_run,
  output logic [1:0] clk_sel,
  output logic       fail_trap
);

  seq_state_e state_q, state_d;
  seq_state_e rel_target;
  clk_src_e   src_q;
  logic       src_ld;
  logic       clk_valid;
  logic       trap_q, trap_d;
  logic       enter_fs;

  assign rel_target = src_needs_settle(src_sel) ? ST_SETTLE : ST_WAIT_CLK;

  always_comb begin
    unique case (src_q)
      SRC_FRC:  clk_valid = 1'b1;
      SRC_XTAL: clk_valid = osc_rdy;
      default:  clk_valid = osc_rdy && pll_lock;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:      if (tmr_done) state_d = pwrt_en ? ST_PWRT : rel_target;
      ST_PWRT:     if (tmr_done) state_d = rel_target;
      ST_SETTLE:   if (tmr_done) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK: begin
        if (mon_fail)       state_d = ST_FAILSAFE;
        else if (clk_valid) state_d = ST_RUN;
      end
      ST_RUN:      if (mon_fail) state_d = ST_FAILSAFE;
      ST_FAILSAFE: state_d = ST_FAILSAFE;
      default:     state_d = ST_POR;
    endcase
  end

  assign tmr_clr  = (state_d != state_q);
  assign enter_fs = (state_d == ST_FAILSAFE) && (state_q != ST_FAILSAFE);
  assign src_ld   = (state_q inside {ST_POR, ST_PWRT}) && tmr_clr && (state_d != ST_PWRT);

  always_comb begin
    if (enter_fs)      trap_d = 1'b1;
    else if (trap_ack) trap_d = 1'b0;
    else               trap_d = trap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_POR;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= SRC_FRC;
    else if (src_ld) src_q <= src_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign state       = state_q;
  assign sys_rst_rel = state_q inside {ST_SETTLE, ST_WAIT_CLK, ST_RUN, ST_FAILSAFE};
  assign cpu_run     = state_q inside {ST_RUN, ST_FAILSAFE};
  assign mon_active  = mon_en && (state_q inside {ST_WAIT_CLK, ST_RUN});
  assign clk_sel     = (state_q == ST_FAILSAFE) ? SRC_FRC : src_q;
  assign fail_trap   = trap_q;

  // R8: trap request holds until acknowledged
  assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q && !trap_ack |=> trap_q);

  // R8: fallback is left only through power-on reset
  assert_failsafe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FAILSAFE |=> state_q == ST_FAILSAFE);

  // R5: execution starts only on a valid clock or a fallback
  assert_run_on_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(clk_valid) || $past(mon_fail));

  // R10: latched source is frozen once reset is released
  assert_src_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_rel && $past(sys_rst_rel) |-> $stable(src_q));

endmodule

// File: rtl/rst_clk_sequencer.sv
module rst_clk_sequencer
  import rstseq_pkg::*;
#(
  parameter int POR_CYCLES    = 64,
  parameter int PWRT_CYCLES   = 2048,
  parameter int SETTLE_CYCLES = 4000,
  parameter int MISS_CYCLES   = 16,
  parameter int SYNC_DEPTH    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrt_en,
  input  logic       mon_en,
  input  logic [1:0] src_sel,
  input  logic       osc_rdy,
  input  logic       pll_lock,
  input  logic       clk_activity,
  input  logic       trap_ack,
  output logic       sys_rst_rel,
  output logic       cpu_run,
  output logic [1:0] clk_sel,
  output logic       fail_trap
);

  localparam int MAX_A = (POR_CYCLES > PWRT_CYCLES) ? POR_CYCLES : PWRT_CYCLES;
  localparam int MAX_D = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
  localparam int CNT_W = $clog2(MAX_D + 1);

  seq_state_e       state;
  logic             tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_lim;
  logic             mon_active, mon_fail;

  always_comb begin
    unique case (state)
      ST_POR:    tmr_lim = CNT_W'(POR_CYCLES);
      ST_PWRT:   tmr_lim = CNT_W'(PWRT_CYCLES);
      ST_SETTLE: tmr_lim = CNT_W'(SETTLE_CYCLES);
      default:   tmr_lim = CNT_W'(1);
    endcase
  end

  rstseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_lim),
    .done  (tmr_done)
  );

  rstseq_clkmon #(.MISS_CYCLES(MISS_CYCLES), .SYNC_DEPTH(SYNC_DEPTH)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (clk_activity),
    .active   (mon_active),
    .fail     (mon_fail)
  );

  rstseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwrt_en     (pwrt_en),
    .mon_en      (mon_en),
    .src_sel     (clk_src_e'(src_sel)),
    .osc_rdy     (osc_rdy),
    .pll_lock    (pll_lock),
    .trap_ack    (trap_ack),
    .mon_fail    (mon_fail),
    .tmr_done    (tmr_done),
    .state       (state),
    .tmr_clr     (tmr_clr),
    .mon_active  (mon_active),
    .sys_rst_rel (sys_rst_rel),
    .cpu_run     (cpu_run),
    .clk_sel     (clk_sel),
    .fail_trap   (fail_trap)
  );

  // R4: no failure is reported before monitoring is allowed to start
  assert_no_early_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_POR, ST_PWRT, ST_SETTLE}) |-> !fail_trap);

  // R6: a raised trap always comes with the RC fallback clock running the CPU
  assert_trap_on_frc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_trap) |-> (clk_sel == 2'b00) && cpu_run);

  // R7: failure while waiting for a clock goes straight to fallback
  assert_fail_beats_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mon_fail && state == ST_WAIT_CLK |=> state == ST_FAILSAFE);

endmodule

// File: tb/test_rst_clk_sequencer.sv
module test_rst_clk_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int POR_C  = 8;
  localparam int PWRT_C = 16;
  localparam int SET_C  = 20;
  localparam int MISS_C = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrt_en = 1'b0, mon_en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic       osc_rdy = 1'b0, pll_lock = 1'b0;
  logic       clk_activity = 1'b0, trap_ack = 1'b0;
  logic       act_run = 1'b0;
  logic       sys_rst_rel, cpu_run, fail_trap;
  logic [1:0] clk_sel;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  rst_clk_sequencer #(
    .POR_CYCLES(POR_C), .PWRT_CYCLES(PWRT_C),
    .SETTLE_CYCLES(SET_C), .MISS_CYCLES(MISS_C)
  ) i_rst_clk_sequencer (
    .clk(clk), .rst_n(rst_n), .pwrt_en(pwrt_en), .mon_en(mon_en),
    .src_sel(src_sel), .osc_rdy(osc_rdy), .pll_lock(pll_lock),
    .clk_activity(clk_activity), .trap_ack(trap_ack),
    .sys_rst_rel(sys_rst_rel), .cpu_run(cpu_run),
    .clk_sel(clk_sel), .fail_trap(fail_trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (act_run) clk_activity = ~clk_activity;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int rel_edge(input bit pw);
    return POR_C + (pw ? PWRT_C : 0);
  endfunction

  function automatic int mon_edge(input bit pw, input logic [1:0] s);
    return rel_edge(pw) + ((s != 2'b00) ? SET_C : 0);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] s, input bit pw, input bit me,
                          input bit ordy, input bit lk, input bit toggle);
    @(negedge clk);
    rst_n = 1'b0;
    act_run = 1'b0;
    clk_activity = 1'b0;
    trap_ack = 1'b0;
    src_sel = s; pwrt_en = pw; mon_en = me; osc_rdy = ordy; pll_lock = lk;
    repeat (2) @(negedge clk);
    check("R1", "rst sys_rst_rel", sys_rst_rel, 0);
    check("R1", "rst cpu_run", cpu_run, 0);
    check("R1", "rst clk_sel", clk_sel, 0);
    check("R1", "rst fail_trap", fail_trap, 0);
    act_run = toggle;
    rst_n = 1'b1;
  endtask

  // healthy clock: every edge checked against computed release/run points
  task automatic seq_check(input logic [1:0] s, input bit pw, input bit me);
    int rel, run;
    do_reset(s, pw, me, 1'b1, 1'b1, 1'b1);
    rel = rel_edge(pw);
    run = mon_edge(pw, s) + 1;
    for (int e = 1; e <= run + 3; e++) begin
      step();
      if (e < POR_C) check("R1", "por window cpu_run", cpu_run, 0);
      check(pw ? "R2" : "R3", "sys_rst_rel", sys_rst_rel, (e >= rel) ? 1 : 0);
      check("R5", "cpu_run", cpu_run, (e >= run) ? 1 : 0);
      check("R10", "clk_sel", clk_sel, (e >= rel) ? int'(s) : 0);
      check("R6", "no trap on healthy clock", fail_trap, 0);
    end
    src_sel = ~s;
    step();
    check("R10", "clk_sel ignores later src_sel", clk_sel, int'(s));
  endtask

  initial begin
    void'($urandom(32'd4242));

    // directed configurations
    seq_check(2'b00, 1'b0, 1'b1);
    seq_check(2'b01, 1'b1, 1'b1);
    seq_check(2'b10, 1'b0, 1'b1);
    seq_check(2'b11, 1'b1, 1'b0);

    // random configurations
    for (int i = 0; i < 8; i++) begin
      seq_check(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
    end

    // crystal with a dead clock: monitoring only after settling (R4, R6)
    begin
      int rel, w;
      do_reset(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      rel = rel_edge(1'b1);
      w = mon_edge(1'b1, 2'b01);
      for (int e = 1; e <= w + MISS_C + 2; e++) begin
        step();
        check("R4", "trap timing", fail_trap, (e >= w + MISS_C) ? 1 : 0);
        check("R6", "cpu_run", cpu_run, (e >= w + 1) ? 1 : 0);
        check("R6", "clk_sel", clk_sel,
              (e < rel || e >= w + MISS_C) ? 0 : 1);
      end
    end

    // failure and PLL lock on the same edge (R7)
    begin
      int w;
      do_reset(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      w = mon_edge(1'b0, 2'b10);
      for (int e = 1; e <= w + MISS_C - 1; e++) begin
        step();
        check("R7", "cpu_run before collision", cpu_run, 0);
        check("R7", "trap before collision", fail_trap, 0);
      end
      osc_rdy = 1'b1;
      pll_lock = 1'b1;
      step();
      check("R7", "trap on collision edge", fail_trap, 1);
      check("R7", "clk_sel on collision edge", clk_sel, 0);
      check("R7", "cpu_run on collision edge", cpu_run, 1);
    end

    // trap hold and acknowledge (R8)
    repeat (3) step();
    check("R8", "trap held without ack", fail_trap, 1);
    trap_ack = 1'b1;
    step();
    trap_ack = 1'b0;
    check("R8", "trap cleared by ack", fail_trap, 0);
    repeat (3) step();
    check("R8", "trap stays clear", fail_trap, 0);
    check("R8", "fallback clock kept", clk_sel, 0);
    check("R8", "cpu keeps running", cpu_run, 1);

    // monitoring disabled: wait for lock, no trap (R9)
    begin
      int w;
      do_reset(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      w = mon_edge(1'b1, 2'b10);
      repeat (w + MISS_C + 5) step();
      check("R9", "released", sys_rst_rel, 1);
      check("R9", "cpu waits for lock", cpu_run, 0);
      check("R9", "no trap while disabled", fail_trap, 0);
      pll_lock = 1'b1;
      step();
      check("R5", "cpu_run after lock", cpu_run, 1);
      check("R9", "clk_sel stays PLL", clk_sel, 2);
      repeat (2 * MISS_C) step();
      check("R9", "still no trap", fail_trap, 0);
    end

    // crystal waits for oscillator ready (R5)
    begin
      int w;
      do_reset(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      w = mon_edge(1'b0, 2'b01);
      repeat (w + 4) step();
      check("R5", "cpu waits for osc_rdy", cpu_run, 0);
      osc_rdy = 1'b1;
      step();
      check("R5", "cpu_run after osc_rdy", cpu_run, 1);
    end

    // clock lost while running on RC (R6)
    do_reset(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (POR_C + 10) step();
    check("R6", "running before loss", cpu_run, 1);
    act_run = 1'b0;
    repeat (MISS_C) step();
    check("R6", "no trap too early", fail_trap, 0);
    repeat (4) step();
    check("R6", "trap after loss", fail_trap, 1);
    check("R6", "clk_sel fallback", clk_sel, 0);

    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

endmodule